// File: doc/BRIEF.md
# Tiled SIMD Integer Vector Unit

This block is a two-dimensional SIMD execution unit. Its datapath is a grid of element ALUs arranged as sublanes by lanes. It owns a register file in which every register holds one complete tile, with one element for each sublane and lane position. Each cycle it can take one instruction that names two source registers, a destination register and an operation. It applies that operation to every element of the tile in the same cycle. The result lands in the destination register two clock edges after the instruction is accepted.

An instruction may depend on the one issued just before it. The operand path therefore picks up the result still in flight from the pipeline, so there is never a stall and issue is sustained at one instruction per cycle. A separate host port loads tiles into registers and reads them back. A read request sees the outcome of every instruction issued before it. Element arithmetic is 32-bit two's-complement integer with wraparound.

Top module: `vxu_top`

## Requirements
- R1: After reset every register reads as all zeros and `host_rvalid` is low.
- R2: Operation code 2'b00 writes the element-wise sum of the two sources, wrapping modulo 2^ELEM_W.
- R3: Operation code 2'b01 writes the element-wise difference src0 minus src1, wrapping modulo 2^ELEM_W.
- R4: Operation code 2'b10 writes the element-wise signed maximum of the two sources.
- R5: Operation code 2'b11 writes the element-wise signed minimum of the two sources.
- R6: Element (s, l) of a tile sits at bits [(s*LANES+l)*ELEM_W +: ELEM_W]. One instruction applies the same operation to every element position independently.
- R7: An instruction can be accepted every cycle. Its result is returned by a host read requested in the very next cycle, and it is in the register file two edges after acceptance.
- R8: An instruction whose source is the destination of the instruction issued one cycle earlier uses that earlier result, with no stall.
- R9: A host write becomes visible to instructions and reads from the following cycle on. An instruction issued in the same cycle reads the old value.
- R10: A host write may land on the same edge as a pipeline writeback to the same register. In that case the writeback value is kept. If the two target different registers, both take effect.
- R11: A host read returns its data with `host_rvalid` high one cycle after the request. `host_rdata` holds its value in cycles with no request.
- R12: A cycle with `in_valid` low changes no register, whatever the other instruction fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | Operation code (00 add, 01 sub, 10 max, 11 min) |
| in_src0 | input | IDX_W | First source register index |
| in_src1 | input | IDX_W | Second source register index |
| in_dst | input | IDX_W | Destination register index |
| host_we | input | 1 | Host write request |
| host_widx | input | IDX_W | Host write register index |
| host_wdata | input | TILE_W | Host write tile |
| host_re | input | 1 | Host read request |
| host_ridx | input | IDX_W | Host read register index |
| host_rvalid | output | 1 | Read data valid, one cycle after request |
| host_rdata | output | TILE_W | Read tile |

## Verification
The assertions assume that `in_valid` and `host_re` are at known levels in every cycle after reset. They also assume that the index fields matter only in cycles where their enable is high, and that the operand and read paths are sampled once per clock edge. The stimulus drives every input to a defined value on the falling edge and keeps all indices inside the register count. Random phases confine sources and destinations to a small pool of registers. That pool makes back-to-back dependencies and writeback/host-write collisions frequent rather than rare.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

   typedef enum logic [1:0] {
      VOP_ADD = 2'b00,
      VOP_SUB = 2'b01,
      VOP_MAX = 2'b10,
      VOP_MIN = 2'b11
   } vop_e;

   localparam int VOP_W = 2;

endpackage

// File: rtl/vxu_elem_alu.sv
module vxu_elem_alu
   import vxu_pkg::*;
#(
   parameter int ELEM_W = 32
) (
   input  vop_e              op,
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   output logic [ELEM_W-1:0] y
);

   logic a_gt_b;
   assign a_gt_b = $signed(a) > $signed(b);

   always_comb begin
      case (op)
         VOP_ADD: y = a + b;
         VOP_SUB: y = a - b;
         VOP_MAX: y = a_gt_b ? a : b;
         default: y = a_gt_b ? b : a;
      endcase
   end

endmodule

// File: rtl/vxu_tile_alu.sv
module vxu_tile_alu
   import vxu_pkg::*;
#(
   parameter int SUBLANES = 8,
   parameter int LANES    = 128,
   parameter int ELEM_W   = 32,
   localparam int TILE_W  = SUBLANES * LANES * ELEM_W
) (
   input  vop_e              op,
   input  logic [TILE_W-1:0] a,
   input  logic [TILE_W-1:0] b,
   output logic [TILE_W-1:0] y
);

   for (genvar s = 0; s < SUBLANES; s++) begin : g_sub
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int BASE = (s * LANES + l) * ELEM_W;
         vxu_elem_alu #(.ELEM_W(ELEM_W)) u_alu (
            .op (op),
            .a  (a[BASE +: ELEM_W]),
            .b  (b[BASE +: ELEM_W]),
            .y  (y[BASE +: ELEM_W])
         );
      end
   end

endmodule

// File: rtl/vxu_regfile.sv
module vxu_regfile #(
   parameter int NUM_REGS = 32,
   parameter int TILE_W   = 1024,
   parameter int NUM_RD   = 3,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [TILE_W-1:0] wb_data,
   input  logic              hw_en,
   input  logic [IDX_W-1:0]  hw_idx,
   input  logic [TILE_W-1:0] hw_data,
   input  logic [IDX_W-1:0]  rd_idx  [NUM_RD],
   output logic [TILE_W-1:0] rd_data [NUM_RD]
);

   logic [TILE_W-1:0] mem [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic wb_hit, hw_hit;
      assign wb_hit = wb_en && (wb_idx == IDX_W'(r));
      assign hw_hit = hw_en && (hw_idx == IDX_W'(r));

      always_ff @(posedge clk) begin
         if (!rst_n)      mem[r] <= '0;
         else if (wb_hit) mem[r] <= wb_data;
         else if (hw_hit) mem[r] <= hw_data;
      end
   end

   for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
      assign rd_data[k] = mem[rd_idx[k]];
   end

endmodule

// File: rtl/vxu_top.sv
module vxu_top
   import vxu_pkg::*;
#(
   parameter int SUBLANES = 8,
   parameter int LANES    = 128,
   parameter int ELEM_W   = 32,
   parameter int NUM_REGS = 32,
   localparam int ELEMS   = SUBLANES * LANES,
   localparam int TILE_W  = ELEMS * ELEM_W,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [IDX_W-1:0]  in_src0,
   input  logic [IDX_W-1:0]  in_src1,
   input  logic [IDX_W-1:0]  in_dst,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_widx,
   input  logic [TILE_W-1:0] host_wdata,
   input  logic              host_re,
   input  logic [IDX_W-1:0]  host_ridx,
   output logic              host_rvalid,
   output logic [TILE_W-1:0] host_rdata
);

   localparam int NUM_RD = 3;
   localparam int RD_A   = 0;
   localparam int RD_B   = 1;
   localparam int RD_H   = 2;

   if (SUBLANES < 1 || LANES < 1) begin : g_bad_shape
      $error("vxu_top: SUBLANES and LANES must be at least 1");
   end
   if (ELEM_W < 2) begin : g_bad_width
      $error("vxu_top: ELEM_W must be at least 2");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("vxu_top: NUM_REGS must be a power of two, at least 2");
   end

   // Execute stage: operands captured at issue, result computed here and
   // written to the register file on the following edge.
   logic              s1_valid;
   vop_e              s1_op;
   logic [IDX_W-1:0]  s1_dst;
   logic [TILE_W-1:0] s1_opnd [2];
   logic [TILE_W-1:0] wb_data;

   logic [IDX_W-1:0]  rd_idx   [NUM_RD];
   logic [TILE_W-1:0] rd_data  [NUM_RD];
   logic [TILE_W-1:0] fwd_data [NUM_RD];

   assign rd_idx[RD_A] = in_src0;
   assign rd_idx[RD_B] = in_src1;
   assign rd_idx[RD_H] = host_ridx;

   vxu_regfile #(
      .NUM_REGS (NUM_REGS),
      .TILE_W   (TILE_W),
      .NUM_RD   (NUM_RD)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wb_en   (s1_valid),
      .wb_idx  (s1_dst),
      .wb_data (wb_data),
      .hw_en   (host_we),
      .hw_idx  (host_widx),
      .hw_data (host_wdata),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   vxu_tile_alu #(
      .SUBLANES (SUBLANES),
      .LANES    (LANES),
      .ELEM_W   (ELEM_W)
   ) u_alu (
      .op (s1_op),
      .a  (s1_opnd[0]),
      .b  (s1_opnd[1]),
      .y  (wb_data)
   );

   // Every read port sees the pending writeback ahead of the array.
   for (genvar k = 0; k < NUM_RD; k++) begin : g_fwd
      assign fwd_data[k] = (s1_valid && (s1_dst == rd_idx[k])) ? wb_data : rd_data[k];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid   <= 1'b0;
         s1_op      <= VOP_ADD;
         s1_dst     <= '0;
         s1_opnd[0] <= '0;
         s1_opnd[1] <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_op      <= vop_e'(in_op);
            s1_dst     <= in_dst;
            s1_opnd[0] <= fwd_data[RD_A];
            s1_opnd[1] <= fwd_data[RD_B];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_rdata  <= '0;
      end else begin
         host_rvalid <= host_re;
         if (host_re) host_rdata <= fwd_data[RD_H];
      end
   end

endmodule

// File: rtl/vxu_checker.sv
module vxu_checker #(
   parameter int TILE_W = 1024,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [IDX_W-1:0]  in_src0,
   input logic [IDX_W-1:0]  in_src1,
   input logic              host_re,
   input logic [IDX_W-1:0]  host_ridx,
   input logic              host_rvalid,
   input logic [TILE_W-1:0] host_rdata,
   input logic              s1_valid,
   input logic [IDX_W-1:0]  s1_dst,
   input logic [TILE_W-1:0] s1_opa,
   input logic [TILE_W-1:0] s1_opb,
   input logic [TILE_W-1:0] wb_data,
   input logic [TILE_W-1:0] rf_a,
   input logic [TILE_W-1:0] rf_b
);

   p_fwd_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && s1_valid && (in_src0 == s1_dst) |=> s1_opa == $past(wb_data));

   p_fwd_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && s1_valid && (in_src1 == s1_dst) |=> s1_opb == $past(wb_data));

   p_rf_operand_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(s1_valid && (in_src0 == s1_dst)) |=> s1_opa == $past(rf_a));

   p_rf_operand_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !(s1_valid && (in_src1 == s1_dst)) |=> s1_opb == $past(rf_b));

   p_read_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_re && s1_valid && (host_ridx == s1_dst) |=> host_rdata == $past(wb_data));

   p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !host_re |=> $stable(host_rdata) && !host_rvalid);

   p_read_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      host_re |=> host_rvalid);

   p_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);

endmodule

bind vxu_top vxu_checker #(.TILE_W(TILE_W), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_src0     (in_src0),
   .in_src1     (in_src1),
   .host_re     (host_re),
   .host_ridx   (host_ridx),
   .host_rvalid (host_rvalid),
   .host_rdata  (host_rdata),
   .s1_valid    (s1_valid),
   .s1_dst      (s1_dst),
   .s1_opa      (s1_opnd[0]),
   .s1_opb      (s1_opnd[1]),
   .wb_data     (wb_data),
   .rf_a        (rd_data[0]),
   .rf_b        (rd_data[1])
);

// File: tb/sim_vxu_top.sv
`timescale 1ns/1ps
module sim_vxu_top;

   localparam int SL = 8;
   localparam int LN = 4;
   localparam int EW = 32;
   localparam int NR = 32;
   localparam int EL = SL * LN;
   localparam int TW = EL * EW;
   localparam int IW = $clog2(NR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = '0;
   logic [IW-1:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
   logic          host_we = 1'b0;
   logic [IW-1:0] host_widx = '0;
   logic [TW-1:0] host_wdata = '0;
   logic          host_re = 1'b0;
   logic [IW-1:0] host_ridx = '0;
   logic          host_rvalid;
   logic [TW-1:0] host_rdata;

   always #4 clk = ~clk;

   vxu_top #(.SUBLANES(SL), .LANES(LN), .ELEM_W(EW), .NUM_REGS(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
      .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
      .host_re(host_re), .host_ridx(host_ridx),
      .host_rvalid(host_rvalid), .host_rdata(host_rdata)
   );

   logic [TW-1:0] ref_rf [NR];
   logic [TW-1:0] exp_q [$];
   string         tag_q [$];
   int            n_chk = 0, n_bad = 0;
   bit            prev_v = 1'b0;
   logic [IW-1:0] prev_d = '0;
   bit            done = 1'b0;

   function automatic logic [TW-1:0] tile_op(input logic [1:0] op,
                                              input logic [TW-1:0] a, input logic [TW-1:0] b);
      logic [TW-1:0] r;
      r = '0;
      for (int e = 0; e < EL; e++) begin
         logic signed [EW-1:0] x, y;
         x = a[e*EW +: EW];
         y = b[e*EW +: EW];
         case (op)
            2'b00:   r[e*EW +: EW] = x + y;
            2'b01:   r[e*EW +: EW] = x - y;
            2'b10:   r[e*EW +: EW] = (x > y) ? x : y;
            default: r[e*EW +: EW] = (x < y) ? x : y;
         endcase
      end
      return r;
   endfunction

   function automatic logic [TW-1:0] rand_tile();
      logic [TW-1:0] t;
      for (int e = 0; e < EL; e++) begin
         case ($urandom % 6)
            0:       t[e*EW +: EW] = 32'h7FFF_FFFF;
            1:       t[e*EW +: EW] = 32'h8000_0000;
            2:       t[e*EW +: EW] = 32'hFFFF_FFFF;
            3:       t[e*EW +: EW] = 32'h0000_0000;
            default: t[e*EW +: EW] = $urandom;
         endcase
      end
      return t;
   endfunction

   // Driver: applies one cycle of stimulus and updates the reference model.
   task automatic cyc(input bit iv, input logic [1:0] op, input logic [IW-1:0] s0,
                      input logic [IW-1:0] s1, input logic [IW-1:0] d,
                      input bit hw, input logic [IW-1:0] widx, input logic [TW-1:0] wdata,
                      input bit hr, input logic [IW-1:0] ridx, input string tag);
      logic [TW-1:0] res;
      @(negedge clk);
      in_valid = iv; in_op = op; in_src0 = s0; in_src1 = s1; in_dst = d;
      host_we = hw; host_widx = widx; host_wdata = wdata;
      host_re = hr; host_ridx = ridx;
      if (hr) begin
         exp_q.push_back(ref_rf[ridx]);
         tag_q.push_back(tag);
      end
      res = tile_op(op, ref_rf[s0], ref_rf[s1]);
      if (hw && !(prev_v && prev_d == widx)) ref_rf[widx] = wdata;
      if (iv) ref_rf[d] = res;
      prev_v = iv;
      prev_d = d;
   endtask

   task automatic idle();
      cyc(0, 2'b00, '0, '0, '0, 0, '0, '0, 0, '0, "");
   endtask

   task automatic ins(input logic [1:0] op, input int s0, input int s1, input int d);
      cyc(1, op, IW'(s0), IW'(s1), IW'(d), 0, '0, '0, 0, '0, "");
   endtask

   task automatic hwr(input int idx, input logic [TW-1:0] v);
      cyc(0, 2'b00, '0, '0, '0, 1, IW'(idx), v, 0, '0, "");
   endtask

   task automatic hrd(input int idx, input string tag);
      cyc(0, 2'b00, '0, '0, '0, 0, '0, '0, 1, IW'(idx), tag);
   endtask

   // Monitor: compares each returned tile with the queued expectation.
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R11: unexpected host_rvalid, data=%h expected no response", host_rdata);
         end else begin
            logic [TW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (host_rdata !== e) begin
               n_bad++;
               $display("FAIL %s: read data actual=%h expected=%h", t, host_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [TW-1:0] ta, tb, tc;
      for (int r = 0; r < NR; r++) ref_rf[r] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: no read response pending out of reset
      n_chk++;
      if (host_rvalid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: host_rvalid actual=%b expected=0", host_rvalid);
      end
      for (int r = 0; r < NR; r++) hrd(r, "R1");

      // R2..R5, R6: each operation on edge-heavy tiles
      ta = rand_tile();
      ta[0 +: EW] = 32'h7FFF_FFFF;
      tb = rand_tile();
      tb[0 +: EW] = 32'h0000_0001;
      hwr(1, ta);
      hwr(2, tb);
      ins(2'b00, 1, 2, 3);
      ins(2'b01, 1, 2, 4);
      ins(2'b10, 1, 2, 5);
      ins(2'b11, 1, 2, 6);
      idle();
      hrd(3, "R2");
      hrd(4, "R3");
      hrd(5, "R4");
      hrd(6, "R5");
      tc = '0;
      for (int e = 0; e < EL; e++) tc[e*EW +: EW] = EW'(e * 3 - 40);
      hwr(16, tc);
      ins(2'b01, 16, 2, 17);
      idle();
      hrd(17, "R6");

      // R8: dependent chain back to back
      ins(2'b00, 1, 2, 7);
      ins(2'b01, 7, 1, 8);
      ins(2'b10, 8, 7, 9);
      ins(2'b11, 9, 9, 9);
      idle();
      hrd(7, "R8");
      hrd(8, "R8");
      hrd(9, "R8");

      // R7: read in the cycle right after issue
      ins(2'b10, 1, 2, 15);
      hrd(15, "R7");

      // R9: host write and same-cycle instruction reading it
      hwr(10, rand_tile());
      cyc(1, 2'b00, IW'(10), IW'(10), IW'(11), 1, IW'(10), rand_tile(), 0, '0, "");
      idle();
      hrd(11, "R9");
      hrd(10, "R9");

      // R10: collision with writeback, then non-colliding pair
      ins(2'b00, 1, 2, 12);
      hwr(12, rand_tile());
      idle();
      hrd(12, "R10");
      ins(2'b01, 1, 2, 13);
      hwr(14, rand_tile());
      idle();
      hrd(13, "R10");
      hrd(14, "R10");

      // R12: inactive instruction fields
      cyc(0, 2'b01, IW'(1), IW'(2), IW'(3), 0, '0, '0, 0, '0, "");
      cyc(0, 2'b00, IW'(4), IW'(4), IW'(4), 0, '0, '0, 0, '0, "");
      idle();
      hrd(3, "R12");
      hrd(4, "R12");

      // R8, R10, R11: random dependent traffic on a small register pool
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 4) != 0, 2'($urandom), IW'($urandom % 8), IW'($urandom % 8),
             IW'($urandom % 8), ($urandom % 5) == 0, IW'($urandom % 8), rand_tile(),
             ($urandom % 3) == 0, IW'($urandom % 8), "R8");
      end
      idle();
      for (int r = 0; r < NR; r++) hrd(r, "R10");
      repeat (3) idle();

      n_chk++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R11: missing read responses actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule